// File: doc/BRIEF.md
# Command Queue Control Register File

This block is the software-visible control slice of a command queue. It holds the queue's 64-bit base pointer, two 32-bit ring indices (producer and consumer) and a control word whose bit 0 enables the queue. Two read-only identification words are also held here. They take fixed values from parameters at reset.

Software reaches the block over a single-cycle register bus that carries an address, a write enable, 64 bits of write data and a size code. Reads are combinational from the addressed register. While the queue is enabled, the base pointer and the consumer index are frozen, and writes to them are dropped. A base write that is accepted also returns both indices to zero, so a new ring always starts empty.

Top module: `cq_ctrl_regs`

## Requirements
- R1: After reset the control word, base, producer and consumer read zero, `size_err` and `wr_ignored` are 0, and the identification words read their parameter values.
- R2: A 32-bit write to the consumer index (offset 0x14) updates it while the enable bit is clear and leaves it unchanged while the enable bit is set.
- R3: A 64-bit write to the base register (offset 0x08) updates it while the enable bit is clear and leaves it unchanged while the enable bit is set.
- R4: An accepted base write sets both the producer and consumer indices to zero on the same clock edge. A dropped base write leaves them unchanged.
- R5: A 32-bit write to the producer index (offset 0x10) always updates it, whether or not the queue is enabled.
- R6: The identification words (offsets 0x20 and 0x24) ignore writes and keep their parameter values.
- R7: Reads return the stored value of the register at `bus_addr`. 32-bit registers appear in bits 31:0 with the upper bits zero. Unmapped offsets read zero, and writes to them have no effect.
- R8: The size code is 2'b10 for a 4-byte access and 2'b11 for an 8-byte access. The base register takes 8 bytes and every other mapped register takes 4 bytes. A write to a mapped register with any other code leaves the register unchanged and sets `size_err`. `size_err` stays set until reset.
- R9: `wr_ignored` is high for exactly the one cycle after the edge that drops a correctly sized write. A write is dropped when it targets base or consumer while the queue is enabled, or when it targets an identification word. In every other cycle `wr_ignored` is low.
- R10: The control word (offset 0x00) stores only bit 0, the enable bit, and its other bits read zero. Clearing the enable bit makes base and consumer writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 64 | Write data, 32-bit registers use bits 31:0 |
| bus_size | input | 2 | Access size code (2'b10 = 4 bytes, 2'b11 = 8 bytes) |
| bus_rdata | output | 64 | Read data for `bus_addr` |
| size_err | output | 1 | Sticky access-size error |
| wr_ignored | output | 1 | One-cycle pulse for a dropped write |

## Verification
The hardest case to reach from the ports is the interaction between the lock and the index clearing. To test it, the indices must first hold non-zero values, then the queue is enabled and a base write is attempted, and the bench must show that neither the base nor the indices moved. The vector table builds this up in order: it loads the indices, performs an accepted base write and reads back the cleared indices, reloads the producer, sets the enable bit, and only then issues the locked base and consumer writes and reads back every affected register. Directed tests then cover the one-cycle timing of `wr_ignored` and the mismatched size code that sets the sticky error.

// File: rtl/cqr_pkg.sv
package cqr_pkg;

  localparam int OFF_CTRL = 32'h00;
  localparam int OFF_BASE = 32'h08;
  localparam int OFF_PROD = 32'h10;
  localparam int OFF_CONS = 32'h14;
  localparam int OFF_ID0  = 32'h20;
  localparam int OFF_ID1  = 32'h24;

  localparam logic [1:0] SZ_32 = 2'b10;
  localparam logic [1:0] SZ_64 = 2'b11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_BASE, SEL_PROD, SEL_CONS, SEL_ID0, SEL_ID1
  } sel_e;

  function automatic sel_e decode_sel(input logic [31:0] a);
    case (a)
      OFF_CTRL: decode_sel = SEL_CTRL;
      OFF_BASE: decode_sel = SEL_BASE;
      OFF_PROD: decode_sel = SEL_PROD;
      OFF_CONS: decode_sel = SEL_CONS;
      OFF_ID0:  decode_sel = SEL_ID0;
      OFF_ID1:  decode_sel = SEL_ID1;
      default:  decode_sel = SEL_NONE;
    endcase
  endfunction

  function automatic logic [1:0] width_code(input sel_e s);
    width_code = (s == SEL_BASE) ? SZ_64 : SZ_32;
  endfunction

  function automatic logic is_locked(input sel_e s, input logic en);
    is_locked = ((s == SEL_BASE || s == SEL_CONS) && en) ||
                s == SEL_ID0 || s == SEL_ID1;
  endfunction

endpackage

// File: rtl/cqr_decode.sv
module cqr_decode
  import cqr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic          q_en,
  output sel_e          sel,
  output logic          wr_accept,
  output logic          wr_drop,
  output logic          size_bad
);
  logic mapped;
  logic size_match;

  always_comb begin
    sel        = decode_sel(32'(addr));
    mapped     = (sel != SEL_NONE);
    size_match = (size == width_code(sel));
    size_bad   = we && mapped && !size_match;
    wr_drop    = we && mapped && size_match && is_locked(sel, q_en);
    wr_accept  = we && mapped && size_match && !is_locked(sel, q_en);
  end
endmodule

// File: rtl/cqr_store.sv
module cqr_store
  import cqr_pkg::*;
#(
  parameter int          DW      = 64,
  parameter int          IW      = 32,
  parameter logic [31:0] ID0_VAL = 32'h0000_0001,
  parameter logic [31:0] ID1_VAL = 32'h0000_0002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sel_e          sel,
  input  logic          wr_accept,
  input  logic [DW-1:0] wdata,
  output logic          en_q,
  output logic [DW-1:0] base_q,
  output logic [IW-1:0] prod_q,
  output logic [IW-1:0] cons_q,
  output logic [31:0]   id0_q,
  output logic [31:0]   id1_q
);
  logic base_wr;
  assign base_wr = wr_accept && sel == SEL_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      prod_q <= '0;
      cons_q <= '0;
      id0_q  <= ID0_VAL;
      id1_q  <= ID1_VAL;
    end else begin
      id0_q <= id0_q;
      id1_q <= id1_q;
      if (wr_accept && sel == SEL_CTRL) en_q <= wdata[0];
      if (base_wr) begin
        base_q <= wdata;
        prod_q <= '0;
        cons_q <= '0;
      end else begin
        if (wr_accept && sel == SEL_PROD) prod_q <= wdata[IW-1:0];
        if (wr_accept && sel == SEL_CONS) cons_q <= wdata[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/cqr_flags.sv
module cqr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic size_bad,
  input  logic wr_drop,
  output logic size_err,
  output logic wr_ignored
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_err   <= 1'b0;
      wr_ignored <= 1'b0;
    end else begin
      size_err   <= size_err | size_bad;
      wr_ignored <= wr_drop;
    end
  end
endmodule

// File: rtl/cq_ctrl_regs.sv
module cq_ctrl_regs
  import cqr_pkg::*;
#(
  parameter int          AW      = 8,
  parameter logic [31:0] ID0_VAL = 32'h0000_0001,
  parameter logic [31:0] ID1_VAL = 32'h0000_0002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [63:0]   bus_wdata,
  input  logic [1:0]    bus_size,
  output logic [63:0]   bus_rdata,
  output logic          size_err,
  output logic          wr_ignored
);
  localparam int DW = 64;
  localparam int IW = DW / 2;

  sel_e          sel;
  logic          wr_accept, wr_drop, size_bad;
  logic          en_q;
  logic [DW-1:0] base_q;
  logic [IW-1:0] prod_q, cons_q;
  logic [31:0]   id0_q, id1_q;

  cqr_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .we(bus_we), .size(bus_size), .q_en(en_q),
    .sel(sel), .wr_accept(wr_accept), .wr_drop(wr_drop), .size_bad(size_bad)
  );

  cqr_store #(.DW(DW), .IW(IW), .ID0_VAL(ID0_VAL), .ID1_VAL(ID1_VAL)) u_store (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_accept(wr_accept),
    .wdata(bus_wdata), .en_q(en_q), .base_q(base_q), .prod_q(prod_q),
    .cons_q(cons_q), .id0_q(id0_q), .id1_q(id1_q)
  );

  cqr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .size_bad(size_bad), .wr_drop(wr_drop),
    .size_err(size_err), .wr_ignored(wr_ignored)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: bus_rdata = {63'd0, en_q};
      SEL_BASE: bus_rdata = base_q;
      SEL_PROD: bus_rdata = {{(DW-IW){1'b0}}, prod_q};
      SEL_CONS: bus_rdata = {{(DW-IW){1'b0}}, cons_q};
      SEL_ID0:  bus_rdata = {32'd0, id0_q};
      SEL_ID1:  bus_rdata = {32'd0, id1_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cqr_checker.sv
module cqr_checker
  import cqr_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [1:0]    bus_size,
  input logic          q_en,
  input logic [63:0]   base_q,
  input logic [31:0]   prod_q,
  input logic [31:0]   cons_q,
  input logic          size_err,
  input logic          wr_ignored
);
  logic hit_base, hit_cons;
  assign hit_base = bus_we && 32'(bus_addr) == OFF_BASE && bus_size == SZ_64;
  assign hit_cons = bus_we && 32'(bus_addr) == OFF_CONS && bus_size == SZ_32;

  p_cons_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cons && q_en) |=> $stable(cons_q));

  p_base_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_base && q_en) |=> $stable(base_q));

  p_base_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_base && !q_en) |=> (prod_q == 32'd0 && cons_q == 32'd0));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);

  p_drop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_base || hit_cons) && q_en) |=> wr_ignored);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> !wr_ignored);
endmodule

bind cq_ctrl_regs cqr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_size(bus_size), .q_en(en_q), .base_q(base_q), .prod_q(prod_q),
  .cons_q(cons_q), .size_err(size_err), .wr_ignored(wr_ignored)
);

// File: tb/cq_ctrl_regs_test.sv
module cq_ctrl_regs_test;
  localparam logic [31:0] ID0 = 32'h0A0B_0C0D;
  localparam logic [31:0] ID1 = 32'h1122_3344;
  localparam logic [1:0]  S4  = 2'b10;
  localparam logic [1:0]  S8  = 2'b11;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [7:0]  waddr;
    logic [1:0]  wsize;
    logic [63:0] wdata;
    logic [7:0]  raddr;
    logic [63:0] rexp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd7,  1'b1, 8'h10, S4, 64'h11,                  8'h10, 64'h11},                  // R7
    '{4'd2,  1'b1, 8'h14, S4, 64'h22,                  8'h14, 64'h22},                  // R2
    '{4'd3,  1'b1, 8'h08, S8, 64'hDEAD_BEEF_0000_1000, 8'h08, 64'hDEAD_BEEF_0000_1000}, // R3
    '{4'd4,  1'b0, 8'h00, S4, 64'h0,                   8'h10, 64'h0},                   // R4
    '{4'd4,  1'b0, 8'h00, S4, 64'h0,                   8'h14, 64'h0},                   // R4
    '{4'd7,  1'b1, 8'h10, S4, 64'hFFFF_FFFF_FFFF_FFFF, 8'h10, 64'hFFFF_FFFF},           // R7
    '{4'd10, 1'b1, 8'h00, S4, 64'hFFFF_FFFF,           8'h00, 64'h1},                   // R10
    '{4'd2,  1'b1, 8'h14, S4, 64'h5,                   8'h14, 64'h0},                   // R2
    '{4'd3,  1'b1, 8'h08, S8, 64'h1234,                8'h08, 64'hDEAD_BEEF_0000_1000}, // R3
    '{4'd4,  1'b0, 8'h00, S4, 64'h0,                   8'h10, 64'hFFFF_FFFF},           // R4
    '{4'd5,  1'b1, 8'h10, S4, 64'h7,                   8'h10, 64'h7},                   // R5
    '{4'd6,  1'b1, 8'h20, S4, 64'h0,                   8'h20, 64'(ID0)},                // R6
    '{4'd10, 1'b1, 8'h00, S4, 64'h0,                   8'h00, 64'h0},                   // R10
    '{4'd10, 1'b1, 8'h14, S4, 64'h9,                   8'h14, 64'h9},                   // R10
    '{4'd7,  1'b1, 8'h40, S4, 64'h55,                  8'h40, 64'h0}                    // R7
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [63:0] bus_wdata = 0;
  logic [1:0]  bus_size = 0;
  logic [63:0] bus_rdata;
  logic        size_err, wr_ignored;

  int n_chk = 0, n_bad = 0;
  logic done = 0;

  always #4 clk = ~clk;

  cq_ctrl_regs #(.AW(8), .ID0_VAL(ID0), .ID1_VAL(ID1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(bus_rdata),
    .size_err(size_err), .wr_ignored(wr_ignored)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 ctrl", r, 64'h0);
    rd(8'h08, r); check("R1 base", r, 64'h0);
    rd(8'h10, r); check("R1 prod", r, 64'h0);
    rd(8'h14, r); check("R1 cons", r, 64'h0);
    rd(8'h20, r); check("R1 id0", r, 64'(ID0));
    rd(8'h24, r); check("R1 id1", r, 64'(ID1));
    check("R1 size_err", 64'(size_err), 64'h0);
    check("R1 wr_ignored", 64'(wr_ignored), 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].waddr, VEC[i].wsize, VEC[i].wdata);
      rd(VEC[i].raddr, r);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].rexp);
    end
    check("R8 no error from table", 64'(size_err), 64'h0);

    // R9 dropped write pulse timing
    wr(8'h00, S4, 64'h1);
    check("R9 accepted write no pulse", 64'(wr_ignored), 64'h0);
    wr(8'h14, S4, 64'h3);
    check("R9 pulse after dropped write", 64'(wr_ignored), 64'h1);
    @(negedge clk);
    check("R9 pulse lasts one cycle", 64'(wr_ignored), 64'h0);
    wr(8'h24, S4, 64'h0);
    check("R9 pulse on id write", 64'(wr_ignored), 64'h1);
    rd(8'h24, r); check("R6 id1 unchanged", r, 64'(ID1));
    wr(8'h10, S4, 64'hA);
    check("R9 producer write no pulse", 64'(wr_ignored), 64'h0);
    rd(8'h10, r); check("R5 prod while enabled", r, 64'hA);
    wr(8'h00, S4, 64'h0);

    // R8 size mismatch
    wr(8'h10, S8, 64'hBB);
    check("R8 error set", 64'(size_err), 64'h1);
    check("R8 mismatch no pulse", 64'(wr_ignored), 64'h0);
    rd(8'h10, r); check("R8 prod unchanged", r, 64'hA);
    wr(8'h08, S4, 64'hCC);
    rd(8'h08, r); check("R8 base unchanged", r, 64'hDEAD_BEEF_0000_1000);
    wr(8'h10, S4, 64'hD);
    rd(8'h10, r); check("R8 valid write after error", r, 64'hD);
    check("R8 error sticky", 64'(size_err), 64'h1);

    // R4 accepted base write clears indices
    wr(8'h14, S4, 64'h44);
    wr(8'h08, S8, 64'h0000_0001_0000_2000);
    rd(8'h10, r); check("R4 prod cleared", r, 64'h0);
    rd(8'h14, r); check("R4 cons cleared", r, 64'h0);

    // R1 reset clears sticky error
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 error cleared by reset", 64'(size_err), 64'h0);
    rd(8'h08, r); check("R1 base after reset", r, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule